// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block sequences the power-saving states of a small processor subsystem. A single-cycle power-save command carries a mode code that asks for either a deep stop (Sleep) or a CPU-only stop (Idle). In response the block drives clock enables for the CPU, for each peripheral and for the low-rate watchdog clock. It also drives the primary oscillator enable, the clock-failure monitor enable and a one-cycle watchdog-clear pulse. While in Run it tracks the selected clock source. It freezes that selection for the whole low-power period, so the same source is in use again on wake.

Sleep stops the CPU, the oscillator, the clock monitor and every peripheral that depends on the system clock. Peripherals marked as externally clocked stay enabled. The watchdog clock stays on only if the watchdog is enabled. If it is, a watchdog-clear pulse is issued for one cycle just before Sleep takes hold. Idle gates the CPU clock only.

An enabled interrupt request or a watchdog time-out wakes the block from either mode. An asynchronous active-low reset returns it to Run from any state. All control pins are plain level or pulse signals. The block carries no data stream, so there is no valid/ready interface and no back-pressure.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset all clock enables (`cpu_clk_en`, every bit of `periph_clk_en`, `wdt_clk_en`), `osc_en` and `clk_mon_en` are 1, `wdt_clr` is 0 and `clk_src_out` is 0.
- R2: In Run, `save_req` with `save_mode` = 0 (Sleep) while `wdt_enable` = 1 gives, in the next cycle, `wdt_clr` = 1 with all enables still 1, and Sleep in the cycle after that. With `wdt_enable` = 0, Sleep follows in the next cycle and `wdt_clr` stays 0.
- R3: In Sleep, `cpu_clk_en`, `osc_en` and `clk_mon_en` are 0, and `periph_clk_en[i]` equals `periph_ext[i]`.
- R4: In Sleep, `wdt_clk_en` follows `wdt_enable`. In every other state it is 1.
- R5: In Run, `save_req` with `save_mode` = 1 (Idle) gives, in the next cycle, `cpu_clk_en` = 0 with all other enables 1 and `wdt_clr` = 0.
- R6: In Sleep or Idle, any bit i with `irq_req[i]` & `irq_en[i]` = 1, or `wdt_timeout` = 1, returns the block to Run in the next cycle with all enables 1. Requests whose enable bit is 0 leave the state unchanged.
- R7: In Run, `clk_src_out` takes the value of `clk_src_sel` one cycle later. Outside Run it holds, so in the first Run cycle after wake it equals the value it had at entry.
- R8: `save_req` is ignored while in Sleep or Idle, and in Run it is ignored when `save_mode` is 2 or 3.
- R9: Asserting `rst_n` low returns the block to the R1 state at once, from any state.
- R10: `wdt_clr` is never 1 for two cycles in a row, and it is always followed by Sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| save_req | input | 1 | One-cycle power-save command |
| save_mode | input | MODE_W | Mode code: 0 Sleep, 1 Idle, other values ignored |
| irq_req | input | N_IRQ | Interrupt requests |
| irq_en | input | N_IRQ | Per-request enable bits |
| wdt_enable | input | 1 | Watchdog is enabled |
| wdt_timeout | input | 1 | Watchdog time-out event |
| clk_src_sel | input | SRC_W | Clock-source selection requested in Run |
| periph_ext | input | N_PERIPH | Marks peripherals clocked externally (kept on in Sleep) |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | N_PERIPH | Per-peripheral clock enable |
| wdt_clk_en | output | 1 | Low-rate watchdog clock enable |
| osc_en | output | 1 | Primary oscillator enable |
| clk_mon_en | output | 1 | Clock-failure monitor enable |
| wdt_clr | output | 1 | One-cycle watchdog clear |
| clk_src_out | output | SRC_W | Clock-source selection in use |

## Verification
The bench sweeps every mode code against both watchdog settings and several patterns of externally clocked peripherals. It wakes from each interrupt line in turn and from a watchdog time-out. A design that skipped the clear pulse, or issued it for two cycles, would fail the entry sequence. A design that gated externally clocked peripherals, or dropped the watchdog clock while the watchdog was enabled, would show wrong enables in Sleep. While the block is in a low-power state, the bench sends masked interrupts, a second command and a changed clock-source selection. These catch a design that wakes on masked requests, re-enters on a repeated command, or lets the source drift before wake. An asynchronous reset is also applied in mid-Sleep.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_WDCLR = 2'd1,
    ST_SLEEP = 2'd2,
    ST_IDLE  = 2'd3
  } lpm_state_e;
endpackage

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect #(
  parameter int N_IRQ = 4
) (
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             wdt_timeout,
  output logic             wake
);
  logic [N_IRQ-1:0] live;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_mask
    assign live[i] = irq_req[i] & irq_en[i];
  end

  assign wake = (|live) | wdt_timeout;
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int               MODE_W     = 2,
  parameter logic [MODE_W-1:0] CODE_SLEEP = '0,
  parameter logic [MODE_W-1:0] CODE_IDLE  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save_req,
  input  logic [MODE_W-1:0] save_mode,
  input  logic              wdt_enable,
  input  logic              wake,
  output lpm_state_e        state_q
);
  lpm_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (save_req && save_mode == CODE_SLEEP)
          state_d = wdt_enable ? ST_WDCLR : ST_SLEEP;
        else if (save_req && save_mode == CODE_IDLE)
          state_d = ST_IDLE;
      end
      ST_WDCLR: state_d = ST_SLEEP;
      ST_SLEEP, ST_IDLE: if (wake) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  p_idle_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && save_req && save_mode == CODE_IDLE) |=> state_q == ST_IDLE);
  p_wake_to_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SLEEP || state_q == ST_IDLE) && wake) |=> state_q == ST_RUN);
  p_sleep_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && !wake) |=> state_q == ST_SLEEP);
  p_clr_then_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WDCLR) |=> state_q == ST_SLEEP);
endmodule

// File: rtl/lpm_clk_decode.sv
module lpm_clk_decode
  import lpm_pkg::*;
#(
  parameter int N_PERIPH = 4
) (
  input  lpm_state_e          state,
  input  logic                wdt_enable,
  input  logic [N_PERIPH-1:0] periph_ext,
  output logic                cpu_clk_en,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic                wdt_clk_en,
  output logic                osc_en,
  output logic                clk_mon_en,
  output logic                wdt_clr
);
  logic in_sleep;

  assign in_sleep   = (state == ST_SLEEP);
  assign cpu_clk_en = (state == ST_RUN) || (state == ST_WDCLR);
  assign osc_en     = !in_sleep;
  assign clk_mon_en = !in_sleep;
  assign wdt_clk_en = in_sleep ? wdt_enable : 1'b1;
  assign wdt_clr    = (state == ST_WDCLR);

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_per
    assign periph_clk_en[i] = !in_sleep || periph_ext[i];
  end
endmodule

// File: rtl/lpm_src_hold.sv
module lpm_src_hold #(
  parameter int               SRC_W     = 3,
  parameter logic [SRC_W-1:0] RESET_SRC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SRC_W-1:0] sel,
  output logic [SRC_W-1:0] src_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   src_q <= RESET_SRC;
    else if (run) src_q <= sel;
  end

  p_src_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(src_q));
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int MODE_W   = 2,
  parameter int N_IRQ    = 4,
  parameter int N_PERIPH = 4,
  parameter int SRC_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                save_req,
  input  logic [MODE_W-1:0]   save_mode,
  input  logic [N_IRQ-1:0]    irq_req,
  input  logic [N_IRQ-1:0]    irq_en,
  input  logic                wdt_enable,
  input  logic                wdt_timeout,
  input  logic [SRC_W-1:0]    clk_src_sel,
  input  logic [N_PERIPH-1:0] periph_ext,
  output logic                cpu_clk_en,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic                wdt_clk_en,
  output logic                osc_en,
  output logic                clk_mon_en,
  output logic                wdt_clr,
  output logic [SRC_W-1:0]    clk_src_out
);
  localparam logic [MODE_W-1:0] CODE_SLEEP = '0;
  localparam logic [MODE_W-1:0] CODE_IDLE  = MODE_W'(1);

  lpm_state_e state;
  logic       wake;

  lpm_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
    .irq_req(irq_req), .irq_en(irq_en), .wdt_timeout(wdt_timeout), .wake(wake)
  );

  lpm_fsm #(.MODE_W(MODE_W), .CODE_SLEEP(CODE_SLEEP), .CODE_IDLE(CODE_IDLE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .save_req(save_req), .save_mode(save_mode),
    .wdt_enable(wdt_enable), .wake(wake), .state_q(state)
  );

  lpm_clk_decode #(.N_PERIPH(N_PERIPH)) u_dec (
    .state(state), .wdt_enable(wdt_enable), .periph_ext(periph_ext),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .wdt_clk_en(wdt_clk_en),
    .osc_en(osc_en), .clk_mon_en(clk_mon_en), .wdt_clr(wdt_clr)
  );

  lpm_src_hold #(.SRC_W(SRC_W), .RESET_SRC('0)) u_src (
    .clk(clk), .rst_n(rst_n), .run(state == ST_RUN), .sel(clk_src_sel), .src_q(clk_src_out)
  );

  p_clr_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> !wdt_clr);
  p_sleep_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_clr) |=> !cpu_clk_en && !osc_en);
endmodule

// File: tb/lpm_sequencer_test.sv
module lpm_sequencer_test;
  localparam int NI = 4;
  localparam int NP = 4;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic save_req = 1'b0;
  logic [1:0] save_mode = '0;
  logic [NI-1:0] irq_req = '0, irq_en = '0;
  logic wdt_enable = 1'b0, wdt_timeout = 1'b0;
  logic [SW-1:0] clk_src_sel = '0;
  logic [NP-1:0] periph_ext = '0;
  logic cpu_clk_en, wdt_clk_en, osc_en, clk_mon_en, wdt_clr;
  logic [NP-1:0] periph_clk_en;
  logic [SW-1:0] clk_src_out;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lpm_sequencer #(.MODE_W(2), .N_IRQ(NI), .N_PERIPH(NP), .SRC_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .save_req(save_req), .save_mode(save_mode),
    .irq_req(irq_req), .irq_en(irq_en), .wdt_enable(wdt_enable),
    .wdt_timeout(wdt_timeout), .clk_src_sel(clk_src_sel), .periph_ext(periph_ext),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .wdt_clk_en(wdt_clk_en),
    .osc_en(osc_en), .clk_mon_en(clk_mon_en), .wdt_clr(wdt_clr), .clk_src_out(clk_src_out)
  );

  // packed order: cpu, periph[NP-1:0], wdt clk, osc, monitor, clear
  function automatic logic [NP+4:0] pack(logic c, logic [NP-1:0] p, logic w, logic o, logic m, logic k);
    return {c, p, w, o, m, k};
  endfunction
  function automatic logic [NP+4:0] run_vec();
    return pack(1'b1, '1, 1'b1, 1'b1, 1'b1, 1'b0);
  endfunction
  function automatic logic [NP+4:0] sleep_vec(logic w, logic [NP-1:0] e);
    return pack(1'b0, e, w, 1'b0, 1'b0, 1'b0);
  endfunction
  function automatic logic [NP+4:0] idle_vec();
    return pack(1'b0, '1, 1'b1, 1'b1, 1'b1, 1'b0);
  endfunction

  task automatic check(string tag, logic [NP+4:0] exp);
    logic [NP+4:0] got;
    got = {cpu_clk_en, periph_clk_en, wdt_clk_en, osc_en, clk_mon_en, wdt_clr};
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s enables got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic check_src(string tag, logic [SW-1:0] exp);
    vectors++;
    if (clk_src_out !== exp) begin
      miscompares++;
      $display("FAIL %s clk_src_out got %0d expected %0d", tag, clk_src_out, exp);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] ext_pat [4];
    logic [NP+4:0] low_vec;
    logic [SW-1:0] src;
    int combo;
    ext_pat[0] = '0; ext_pat[1] = 4'h5; ext_pat[2] = 4'hA; ext_pat[3] = '1;
    combo = 0;

    #2;
    check("R1 reset", run_vec());
    check_src("R1 reset", '0);
    @(negedge clk); rst_n = 1'b1;

    for (int m = 0; m < 4; m++) begin
      for (int w = 0; w < 2; w++) begin
        for (int x = 0; x < 4; x++) begin
          src = SW'(combo + 1);
          wdt_enable = w[0];
          periph_ext = ext_pat[x];
          clk_src_sel = src;
          irq_en = '0; irq_req = '0;
          @(negedge clk);
          check_src("R7 track", src);
          save_req = 1'b1; save_mode = m[1:0];
          @(negedge clk);
          save_req = 1'b0;
          if (m == 0 && w == 1) begin
            check("R2 clear pulse", pack(1'b1, '1, 1'b1, 1'b1, 1'b1, 1'b1));
            @(negedge clk);
          end
          if (m == 0) low_vec = sleep_vec(w[0], ext_pat[x]);
          else if (m == 1) low_vec = idle_vec();
          else low_vec = run_vec();
          if (m == 0) check("R3 sleep gating", low_vec);
          else if (m == 1) check("R5 idle gating", low_vec);
          else begin
            check("R8 bad code ignored", low_vec);
            continue;
          end
          // disturb: new source, masked requests, a second command
          clk_src_sel = ~src;
          irq_req = '1; irq_en = '0;
          save_req = 1'b1; save_mode = (m == 0) ? 2'd1 : 2'd0;
          @(negedge clk);
          save_req = 1'b0; irq_req = '0;
          check("R6 masked request / R8 command in low power", low_vec);
          check_src("R7 held", src);
          if (m == 0) begin
            wdt_enable = ~w[0];
            #1;
            check("R4 watchdog clock follows enable", sleep_vec(~w[0], ext_pat[x]));
            wdt_enable = w[0];
          end
          // wake from source combo % (NI+1); NI selects the time-out
          if (combo % (NI + 1) == NI) wdt_timeout = 1'b1;
          else begin
            irq_en = NI'(1) << (combo % (NI + 1));
            irq_req = irq_en;
          end
          @(negedge clk);
          wdt_timeout = 1'b0; irq_req = '0; irq_en = '0;
          check("R6 wake", run_vec());
          check_src("R7 restored at wake", src);
          @(negedge clk);
          check_src("R7 tracks after wake", ~src);
          combo++;
        end
      end
    end

    // R9: asynchronous reset in mid-Sleep
    wdt_enable = 1'b0; periph_ext = '0; clk_src_sel = 3'd6;
    @(negedge clk);
    save_req = 1'b1; save_mode = 2'd0;
    @(negedge clk);
    save_req = 1'b0;
    check("R9 in sleep before reset", sleep_vec(1'b0, '0));
    #1 rst_n = 1'b0;
    #1;
    check("R9 async reset", run_vec());
    check_src("R9 async reset", '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R9 stays in run", run_vec());

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule